// File: doc/BRIEF.md
# Indirect Configuration and Port Access Window

This block is the host-facing front end of a bus bridge. Software reaches downstream configuration space and I/O-port space through a small register window. It first writes a target address into an address register. It then reads or writes one of the data registers at a byte offset, and the block issues one downstream cycle of the matching kind with lane enables derived from that offset and the access size. A 32-bit enable register also opens memory windows. Each bit claims one 8 MB region at the top of the address map. A host access whose address falls into an enabled region is forwarded downstream as a memory cycle. Any other address in that space is refused without a downstream cycle.

The downstream side drives the target address one cycle before the data phase. A configuration write would therefore expose the previous cycle's address. To avoid that, the block automatically inserts a throw-away configuration read to the same bus and device with the register field cleared, and only then runs the write. During any downstream cycle the host side reports busy. It ends with a one-cycle done pulse, and read data is delivered with a valid pulse.

Top module: `cfgwin_bridge`

## Requirements
- R1: After reset the block is not busy, issues no downstream request, and both the enable register (offset 0x060) and the address register (offset 0x064) read back zero.
- R2: Accesses to offsets 0x060 and 0x064 complete locally with a done pulse in the cycle after acceptance and no downstream cycle. A write updates only the bytes selected by its lane enables, and a read returns the register through the same lane selection.
- R3: A data access at offsets 0x068..0x06B issues a configuration cycle (kind code 0). Its downstream address is zero in bits 31:24 and carries the bus number (token bits 23:16), the device/function (token bits 15:8) and the register offset rounded down to a dword (token bits 7:2, with bits 1:0 zero).
- R4: Lanes come from the size code and the low offset bits. Size 0 (byte) enables lane off[1:0]. Size 1 (16-bit) enables lanes 3:2 when off[1] is 1 and lanes 1:0 otherwise. Size 2 (32-bit) enables all four lanes and ignores the offset. Write data is shifted left by 8 times the first lane, and read data is shifted right by the same amount and zero-extended above the access size.
- R5: A data access at offsets 0x06C..0x06F issues an I/O-port cycle (kind code 1). Its address is the low 16 bits of the address register, with zeros above, and its lanes follow R4.
- R6: A configuration write first issues a configuration read whose address equals the write's address with bits 7:0 cleared and all lanes enabled. The write cycle follows, and the data of the dummy read is discarded.
- R7: From acceptance until the downstream acknowledge of the last cycle, busy is high and the request and its fields stay stable. Done pulses for one cycle after that acknowledge, and on reads the read-data valid pulses with it.
- R8: A read whose final cycle is acknowledged with abort returns all ones across the access size, zero above.
- R9: A memory-space access whose address has bits 31:28 equal to 0xF and whose enable bit selected by address bits 27:23 is set issues a memory cycle (kind code 2) at the address with bits 1:0 cleared, using lanes from R4.
- R10: A memory-space access that misses every enabled window (including when the enable register is zero) issues no downstream cycle. It ends with done and the miss flag pulsing together and no read-data valid.
- R11: A data access at offsets 0x070..0x073 issues a memory cycle at the address register value with bits 1:0 cleared, regardless of the window enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, accepted while not busy |
| host_space | input | 1 | 1 = memory-space access, 0 = register-window access |
| host_addr | input | 32 | Host byte address (window offset in bits 11:0 when host_space is 0) |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| host_wdata | input | 32 | Write data, right-aligned |
| host_busy | output | 1 | Downstream work in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rvalid | output | 1 | Read data valid pulse |
| host_miss | output | 1 | Memory-space access was not claimed |
| host_rdata | output | 32 | Right-aligned read data |
| dn_req | output | 1 | Downstream cycle request, held until acknowledged |
| dn_kind | output | 2 | Cycle kind: 0 configuration, 1 I/O port, 2 memory |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | 32 | Downstream address |
| dn_be | output | 4 | Downstream lane enables |
| dn_wdata | output | 32 | Downstream write data on its lanes |
| dn_ack | input | 1 | Downstream acknowledge, one cycle |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |
| dn_abort | input | 1 | Master-abort flag, valid with dn_ack |

## Verification
The bench targets the lane arithmetic at odd offsets and 16-bit upper halves. A design that shifted by the wrong lane or failed to mask above the size would hand back neighbouring bytes. It checks that a configuration write is preceded by the dummy read with the register field cleared. A design that skipped the step, or that kept the register field in it, would show one logged cycle instead of two or a wrong first address. The window decode is probed at the lowest and highest regions, at a disabled neighbour, at a matching index with the wrong top nibble and with all enables clear. A decoder that ignored either field would issue a memory cycle where a miss is required. Aborted configuration reads must return ones only within the access size.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int OFS_W   = 12;

  typedef enum logic [1:0] {DK_CFG = 2'b00, DK_IO = 2'b01, DK_MEM = 2'b10} dkind_e;
  typedef enum logic [1:0] {OP_LOCAL = 2'b00, OP_DOWN = 2'b01, OP_MISS = 2'b10} op_e;
  typedef enum logic [1:0] {SQ_IDLE = 2'b00, SQ_STEP = 2'b01, SQ_MAIN = 2'b10} sq_e;

  localparam logic [OFS_W-1:0] OFS_WINEN = 12'h060;
  localparam logic [OFS_W-1:0] OFS_ADDR  = 12'h064;
  localparam logic [OFS_W-1:0] OFS_CFG   = 12'h068;
  localparam logic [OFS_W-1:0] OFS_IO    = 12'h06C;
  localparam logic [OFS_W-1:0] OFS_MEM   = 12'h070;

  // First active lane of an access
  function automatic logic [1:0] lane_of(input logic [1:0] size, input logic [1:0] off);
    case (size)
      2'd0:    lane_of = off;
      2'd1:    lane_of = {off[1], 1'b0};
      default: lane_of = 2'd0;
    endcase
  endfunction

  // Lane enable pattern
  function automatic logic [LANES-1:0] be_of(input logic [1:0] size, input logic [1:0] off);
    case (size)
      2'd0:    be_of = 4'b0001 << off;
      2'd1:    be_of = off[1] ? 4'b1100 : 4'b0011;
      default: be_of = 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] size);
    case (size)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // Move right-aligned data onto its lanes
  function automatic logic [DATA_W-1:0] place(input logic [1:0] lane, input logic [DATA_W-1:0] d);
    place = d << {lane, 3'b000};
  endfunction

  // Take lane data back to the right and clip to size
  function automatic logic [DATA_W-1:0] pick(input logic [1:0] size, input logic [1:0] lane,
                                             input logic [DATA_W-1:0] raw);
    pick = (raw >> {lane, 3'b000}) & size_mask(size);
  endfunction

endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_winen,
  input  logic              wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] win_en,
  output logic [DATA_W-1:0] addr_tok
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_en[g*8 +: 8]   <= '0;
        addr_tok[g*8 +: 8] <= '0;
      end else begin
        if (wr_winen && wr_be[g]) win_en[g*8 +: 8]   <= wr_data[g*8 +: 8];
        if (wr_addr  && wr_be[g]) addr_tok[g*8 +: 8] <= wr_data[g*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'hF000_0000,
  parameter int          WIN_LOG2 = 23,
  parameter int          EN_W     = 32,
  parameter bit          STEP_EN  = 1'b1
) (
  input  logic              space,
  input  logic [31:0]       addr,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EN_W-1:0]   win_en,
  input  logic [DATA_W-1:0] addr_tok,
  output op_e               op,
  output dkind_e            kind,
  output logic [31:0]       tgt_addr,
  output logic [LANES-1:0]  be,
  output logic [1:0]        lane,
  output logic [DATA_W-1:0] wdata_pl,
  output logic              step_need,
  output logic [31:0]       step_addr,
  output logic              sel_winen,
  output logic              sel_addr,
  output logic [DATA_W-1:0] local_rd,
  output logic              win_hit
);

  localparam int IDX_W  = $clog2(EN_W);
  localparam int TOP_LO = WIN_LOG2 + IDX_W;

  logic [OFS_W-1:0] ofs_base;
  logic [IDX_W-1:0] win_idx;

  assign ofs_base = {addr[OFS_W-1:2], 2'b00};
  assign win_idx  = addr[TOP_LO-1:WIN_LOG2];
  assign win_hit  = (addr[31:TOP_LO] == WIN_BASE[31:TOP_LO]) && win_en[win_idx];
  assign lane     = lane_of(size, addr[1:0]);
  assign be       = be_of(size, addr[1:0]);
  assign wdata_pl = place(lane, wdata);

  always_comb begin
    op        = OP_LOCAL;
    kind      = DK_CFG;
    tgt_addr  = '0;
    step_need = 1'b0;
    step_addr = '0;
    sel_winen = 1'b0;
    sel_addr  = 1'b0;
    local_rd  = '0;
    if (space) begin
      if (win_hit) begin
        op       = OP_DOWN;
        kind     = DK_MEM;
        tgt_addr = {addr[31:2], 2'b00};
      end else begin
        op = OP_MISS;
      end
    end else begin
      case (ofs_base)
        OFS_WINEN: begin
          sel_winen = 1'b1;
          local_rd  = win_en;
        end
        OFS_ADDR: begin
          sel_addr = 1'b1;
          local_rd = addr_tok;
        end
        OFS_CFG: begin
          op        = OP_DOWN;
          kind      = DK_CFG;
          tgt_addr  = {8'h00, addr_tok[23:2], 2'b00};
          step_need = STEP_EN && we;
          step_addr = {8'h00, addr_tok[23:8], 8'h00};
        end
        OFS_IO: begin
          op       = OP_DOWN;
          kind     = DK_IO;
          tgt_addr = {16'h0000, addr_tok[15:0]};
        end
        OFS_MEM: begin
          op       = OP_DOWN;
          kind     = DK_MEM;
          tgt_addr = {addr_tok[31:2], 2'b00};
        end
        default: begin
          op = OP_LOCAL;
        end
      endcase
    end
  end

endmodule

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
  import cfgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  op_e               op,
  input  dkind_e            kind,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [1:0]        lane,
  input  logic [LANES-1:0]  be,
  input  logic [31:0]       tgt_addr,
  input  logic [DATA_W-1:0] wdata_pl,
  input  logic              step_need,
  input  logic [31:0]       step_addr,
  input  logic [DATA_W-1:0] local_rd,
  input  logic              dn_ack,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_abort,
  output logic              accept,
  output logic              busy,
  output logic              dn_req,
  output logic [1:0]        dn_kind,
  output logic              dn_we,
  output logic [31:0]       dn_addr,
  output logic [LANES-1:0]  dn_be,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              host_done,
  output logic              host_rvalid,
  output logic              host_miss,
  output logic [DATA_W-1:0] host_rdata
);

  sq_e              st;
  logic [1:0]       r_size;
  logic [1:0]       r_lane;
  logic             r_we;
  logic [31:0]      main_addr;
  logic [LANES-1:0] main_be;
  logic             step_done;
  logic             last_done;

  assign busy      = (st != SQ_IDLE);
  assign dn_req    = busy;
  assign accept    = req && (st == SQ_IDLE);
  assign step_done = (st == SQ_STEP) && dn_ack;
  assign last_done = (st == SQ_MAIN) && dn_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SQ_IDLE;
      r_size      <= '0;
      r_lane      <= '0;
      r_we        <= 1'b0;
      main_addr   <= '0;
      main_be     <= '0;
      dn_kind     <= DK_CFG;
      dn_we       <= 1'b0;
      dn_addr     <= '0;
      dn_be       <= '0;
      dn_wdata    <= '0;
      host_done   <= 1'b0;
      host_rvalid <= 1'b0;
      host_miss   <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_done   <= 1'b0;
      host_rvalid <= 1'b0;
      host_miss   <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (accept) begin
            case (op)
              OP_LOCAL: begin
                host_done <= 1'b1;
                if (!we) begin
                  host_rvalid <= 1'b1;
                  host_rdata  <= pick(size, lane, local_rd);
                end
              end
              OP_MISS: begin
                host_done <= 1'b1;
                host_miss <= 1'b1;
              end
              default: begin
                r_size    <= size;
                r_lane    <= lane;
                r_we      <= we;
                main_addr <= tgt_addr;
                main_be   <= be;
                dn_kind   <= kind;
                dn_wdata  <= wdata_pl;
                if (step_need) begin
                  st      <= SQ_STEP;
                  dn_addr <= step_addr;
                  dn_be   <= '1;
                  dn_we   <= 1'b0;
                end else begin
                  st      <= SQ_MAIN;
                  dn_addr <= tgt_addr;
                  dn_be   <= be;
                  dn_we   <= we;
                end
              end
            endcase
          end
        end
        SQ_STEP: begin
          if (step_done) begin
            st      <= SQ_MAIN;
            dn_addr <= main_addr;
            dn_be   <= main_be;
            dn_we   <= 1'b1;
          end
        end
        SQ_MAIN: begin
          if (last_done) begin
            st        <= SQ_IDLE;
            host_done <= 1'b1;
            if (!r_we) begin
              host_rvalid <= 1'b1;
              host_rdata  <= dn_abort ? size_mask(r_size) : pick(r_size, r_lane, dn_rdata);
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfgwin_bridge.sv
module cfgwin_bridge
  import cfgwin_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'hF000_0000,
  parameter int          WIN_LOG2 = 23,
  parameter bit          STEP_EN  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_space,
  input  logic [31:0] host_addr,
  input  logic        host_we,
  input  logic [1:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic        host_busy,
  output logic        host_done,
  output logic        host_rvalid,
  output logic        host_miss,
  output logic [31:0] host_rdata,
  output logic        dn_req,
  output logic [1:0]  dn_kind,
  output logic        dn_we,
  output logic [31:0] dn_addr,
  output logic [3:0]  dn_be,
  output logic [31:0] dn_wdata,
  input  logic        dn_ack,
  input  logic [31:0] dn_rdata,
  input  logic        dn_abort
);

  op_e               d_op;
  dkind_e            d_kind;
  logic [31:0]       d_addr;
  logic [LANES-1:0]  d_be;
  logic [1:0]        d_lane;
  logic [DATA_W-1:0] d_wdata;
  logic              d_step;
  logic [31:0]       d_step_addr;
  logic              d_sel_winen;
  logic              d_sel_addr;
  logic [DATA_W-1:0] d_local_rd;
  logic              win_hit;
  logic              accept;
  logic              local_wr;
  logic [DATA_W-1:0] win_en;
  logic [DATA_W-1:0] addr_tok;

  assign local_wr = accept && (d_op == OP_LOCAL) && host_we;

  cfgwin_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_winen (local_wr && d_sel_winen),
    .wr_addr  (local_wr && d_sel_addr),
    .wr_be    (d_be),
    .wr_data  (d_wdata),
    .win_en   (win_en),
    .addr_tok (addr_tok)
  );

  cfgwin_decode #(
    .WIN_BASE (WIN_BASE),
    .WIN_LOG2 (WIN_LOG2),
    .EN_W     (DATA_W),
    .STEP_EN  (STEP_EN)
  ) u_dec (
    .space     (host_space),
    .addr      (host_addr),
    .we        (host_we),
    .size      (host_size),
    .wdata     (host_wdata),
    .win_en    (win_en),
    .addr_tok  (addr_tok),
    .op        (d_op),
    .kind      (d_kind),
    .tgt_addr  (d_addr),
    .be        (d_be),
    .lane      (d_lane),
    .wdata_pl  (d_wdata),
    .step_need (d_step),
    .step_addr (d_step_addr),
    .sel_winen (d_sel_winen),
    .sel_addr  (d_sel_addr),
    .local_rd  (d_local_rd),
    .win_hit   (win_hit)
  );

  cfgwin_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (host_req),
    .op          (d_op),
    .kind        (d_kind),
    .we          (host_we),
    .size        (host_size),
    .lane        (d_lane),
    .be          (d_be),
    .tgt_addr    (d_addr),
    .wdata_pl    (d_wdata),
    .step_need   (d_step),
    .step_addr   (d_step_addr),
    .local_rd    (d_local_rd),
    .dn_ack      (dn_ack),
    .dn_rdata    (dn_rdata),
    .dn_abort    (dn_abort),
    .accept      (accept),
    .busy        (host_busy),
    .dn_req      (dn_req),
    .dn_kind     (dn_kind),
    .dn_we       (dn_we),
    .dn_addr     (dn_addr),
    .dn_be       (dn_be),
    .dn_wdata    (dn_wdata),
    .host_done   (host_done),
    .host_rvalid (host_rvalid),
    .host_miss   (host_miss),
    .host_rdata  (host_rdata)
  );

endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk #(
  parameter bit STEP_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_busy,
  input logic        host_done,
  input logic        host_rvalid,
  input logic        host_miss,
  input logic        dn_req,
  input logic [1:0]  dn_kind,
  input logic        dn_we,
  input logic [31:0] dn_addr,
  input logic [3:0]  dn_be,
  input logic        dn_ack
);

  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_be) && $stable(dn_we) && $stable(dn_kind)); // R7

  AST_BUSY_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> host_busy); // R7

  AST_RVALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> host_done && !host_busy); // R7

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> ($countones(dn_be) == 1 || dn_be == 4'b0011 || dn_be == 4'b1100 || dn_be == 4'b1111)); // R4

  AST_CFG_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_kind == 2'b00 |-> dn_addr[1:0] == 2'b00 && dn_addr[31:24] == 8'h00); // R3

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    host_miss |-> host_done && !host_rvalid && !dn_req); // R10

  if (STEP_EN) begin : g_step
    AST_STEP_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && dn_kind == 2'b00 && dn_we) && !$past(dn_req && dn_kind == 2'b00 && dn_we)
      |-> $past(dn_req && dn_ack && dn_kind == 2'b00 && !dn_we && dn_addr[7:0] == 8'h00)); // R6
  end

endmodule

bind cfgwin_bridge cfgwin_chk #(.STEP_EN(STEP_EN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_busy   (host_busy),
  .host_done   (host_done),
  .host_rvalid (host_rvalid),
  .host_miss   (host_miss),
  .dn_req      (dn_req),
  .dn_kind     (dn_kind),
  .dn_we       (dn_we),
  .dn_addr     (dn_addr),
  .dn_be       (dn_be),
  .dn_ack      (dn_ack)
);

// File: tb/cfgwin_bridge_test.sv
`timescale 1ns/1ps
module cfgwin_bridge_test;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_space = 1'b0;
  logic [31:0] host_addr = '0;
  logic        host_we = 1'b0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_busy, host_done, host_rvalid, host_miss;
  logic [31:0] host_rdata;
  logic        dn_req, dn_we;
  logic [1:0]  dn_kind;
  logic [31:0] dn_addr, dn_wdata;
  logic [3:0]  dn_be;
  logic        dn_ack = 1'b0;
  logic [31:0] dn_rdata = '0;
  logic        dn_abort = 1'b0;

  logic [31:0] rsp_data = '0;
  logic        rsp_abort = 1'b0;

  logic [1:0]  lg_kind [0:63];
  logic        lg_we   [0:63];
  logic [31:0] lg_addr [0:63];
  logic [3:0]  lg_be   [0:63];
  logic [31:0] lg_wdat [0:63];
  int n_log = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  cfgwin_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_space(host_space),
    .host_addr(host_addr), .host_we(host_we), .host_size(host_size), .host_wdata(host_wdata),
    .host_busy(host_busy), .host_done(host_done), .host_rvalid(host_rvalid),
    .host_miss(host_miss), .host_rdata(host_rdata), .dn_req(dn_req), .dn_kind(dn_kind),
    .dn_we(dn_we), .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata), .dn_abort(dn_abort)
  );

  // Downstream responder: logs each cycle, acknowledges after LAT cycles
  initial begin
    forever begin
      @(negedge clk);
      if (dn_req) begin
        if (n_log < 64) begin
          lg_kind[n_log] = dn_kind;
          lg_we[n_log]   = dn_we;
          lg_addr[n_log] = dn_addr;
          lg_be[n_log]   = dn_be;
          lg_wdat[n_log] = dn_wdata;
        end
        n_log++;
        repeat (LAT) @(negedge clk);
        dn_ack   = 1'b1;
        dn_rdata = rsp_data;
        dn_abort = rsp_abort;
        @(negedge clk);
        dn_ack   = 1'b0;
        dn_abort = 1'b0;
      end
    end
  end

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic sp, input logic [31:0] a, input logic we,
                         input logic [1:0] sz, input logic [31:0] wd,
                         output logic [31:0] rd, output logic rv,
                         output logic ms, output logic bz);
    int guard;
    @(negedge clk);
    host_req = 1'b1; host_space = sp; host_addr = a;
    host_we = we; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    bz = host_busy;
    guard = 0;
    while (!host_done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 1000) chk("R7 done timeout", 32'd1, 32'd0);
    rd = host_rdata; rv = host_rvalid; ms = host_miss;
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic rv, ms, bz;
    chk("R1 busy", {31'd0, host_busy}, 32'd0);
    chk("R1 dn_req", {31'd0, dn_req}, 32'd0);
    host_op(0, 32'h060, 0, 2, 0, rd, rv, ms, bz);
    chk("R1 enable reg", rd, 32'd0);
    host_op(0, 32'h064, 0, 2, 0, rd, rv, ms, bz);
    chk("R1 address reg", rd, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] rd; logic rv, ms, bz; int base;
    base = n_log;
    host_op(0, 32'h064, 1, 2, 32'h0012_3447, rd, rv, ms, bz);
    chk("R2 local not busy", {31'd0, bz}, 32'd0);
    host_op(0, 32'h065, 1, 0, 32'h0000_00AB, rd, rv, ms, bz);
    host_op(0, 32'h064, 0, 2, 0, rd, rv, ms, bz);
    chk("R2 byte lane write", rd, 32'h0012_AB47);
    chk("R2 rvalid", {31'd0, rv}, 32'd1);
    host_op(0, 32'h066, 0, 0, 0, rd, rv, ms, bz);
    chk("R2 byte read", rd, 32'h0000_0012);
    host_op(0, 32'h060, 1, 2, 32'h0000_0005, rd, rv, ms, bz);
    host_op(0, 32'h060, 0, 2, 0, rd, rv, ms, bz);
    chk("R2 enable readback", rd, 32'h0000_0005);
    chk("R2 no downstream", n_log - base, 0);
    host_op(0, 32'h064, 1, 2, 32'h0012_3447, rd, rv, ms, bz);
    host_op(0, 32'h060, 1, 2, 32'h0000_0000, rd, rv, ms, bz);
  endtask

  task automatic t_cfg_read();
    logic [31:0] rd; logic rv, ms, bz; int base;
    rsp_data = 32'hAABB_CCDD;
    base = n_log;
    host_op(0, 32'h069, 0, 0, 0, rd, rv, ms, bz);
    chk("R7 busy during cycle", {31'd0, bz}, 32'd1);
    chk("R7 rvalid on read", {31'd0, rv}, 32'd1);
    chk("R3 kind", {30'd0, lg_kind[base]}, 32'd0);
    chk("R3 address", lg_addr[base], 32'h0012_3444);
    chk("R3 read", {31'd0, lg_we[base]}, 32'd0);
    chk("R4 byte be", {28'd0, lg_be[base]}, 32'h2);
    chk("R4 byte data", rd, 32'h0000_00CC);
    host_op(0, 32'h06A, 0, 1, 0, rd, rv, ms, bz);
    chk("R4 upper half be", {28'd0, lg_be[base+1]}, 32'hC);
    chk("R4 upper half data", rd, 32'h0000_AABB);
    host_op(0, 32'h068, 0, 2, 0, rd, rv, ms, bz);
    chk("R4 word be", {28'd0, lg_be[base+2]}, 32'hF);
    chk("R4 word data", rd, 32'hAABB_CCDD);
    chk("R3 one cycle per read", n_log - base, 3);
  endtask

  task automatic t_cfg_write();
    logic [31:0] rd; logic rv, ms, bz; int base;
    base = n_log;
    host_op(0, 32'h06B, 1, 0, 32'h0000_005A, rd, rv, ms, bz);
    chk("R6 two cycles", n_log - base, 2);
    chk("R6 step is read", {31'd0, lg_we[base]}, 32'd0);
    chk("R6 step kind", {30'd0, lg_kind[base]}, 32'd0);
    chk("R6 step address", lg_addr[base], 32'h0012_3400);
    chk("R6 write second", {31'd0, lg_we[base+1]}, 32'd1);
    chk("R6 write address", lg_addr[base+1], 32'h0012_3444);
    chk("R4 write be", {28'd0, lg_be[base+1]}, 32'h8);
    chk("R4 write lane data", lg_wdat[base+1], 32'h5A00_0000);
    chk("R7 no rvalid on write", {31'd0, rv}, 32'd0);
  endtask

  task automatic t_io();
    logic [31:0] rd; logic rv, ms, bz; int base;
    host_op(0, 32'h064, 1, 2, 32'h0000_03F8, rd, rv, ms, bz);
    base = n_log;
    host_op(0, 32'h06E, 1, 1, 32'h0000_1234, rd, rv, ms, bz);
    chk("R5 single cycle", n_log - base, 1);
    chk("R5 kind", {30'd0, lg_kind[base]}, 32'd1);
    chk("R5 port address", lg_addr[base], 32'h0000_03F8);
    chk("R5 be", {28'd0, lg_be[base]}, 32'hC);
    chk("R5 data lanes", lg_wdat[base], 32'h1234_0000);
    rsp_data = 32'h1122_3344;
    host_op(0, 32'h06C, 0, 0, 0, rd, rv, ms, bz);
    chk("R5 byte be", {28'd0, lg_be[base+1]}, 32'h1);
    chk("R5 byte read", rd, 32'h0000_0044);
  endtask

  task automatic t_abort();
    logic [31:0] rd; logic rv, ms, bz;
    host_op(0, 32'h064, 1, 2, 32'h0012_3447, rd, rv, ms, bz);
    rsp_abort = 1'b1;
    rsp_data  = 32'h0000_0000;
    host_op(0, 32'h068, 0, 1, 0, rd, rv, ms, bz);
    chk("R8 half abort", rd, 32'h0000_FFFF);
    host_op(0, 32'h068, 0, 2, 0, rd, rv, ms, bz);
    chk("R8 word abort", rd, 32'hFFFF_FFFF);
    rsp_abort = 1'b0;
  endtask

  task automatic t_window();
    logic [31:0] rd; logic rv, ms, bz; int base;
    base = n_log;
    host_op(1, 32'hF000_0010, 0, 2, 0, rd, rv, ms, bz);
    chk("R10 all disabled miss", {31'd0, ms}, 32'd1);
    chk("R10 no rvalid", {31'd0, rv}, 32'd0);
    chk("R10 no cycle", n_log - base, 0);
    host_op(0, 32'h060, 1, 2, 32'h8000_0001, rd, rv, ms, bz);
    rsp_data = 32'hCAFE_F00D;
    base = n_log;
    host_op(1, 32'hF000_0010, 0, 2, 0, rd, rv, ms, bz);
    chk("R9 lowest window hit", {31'd0, ms}, 32'd0);
    chk("R9 kind", {30'd0, lg_kind[base]}, 32'd2);
    chk("R9 address", lg_addr[base], 32'hF000_0010);
    chk("R9 data", rd, 32'hCAFE_F00D);
    host_op(1, 32'hFF80_0006, 1, 0, 32'h0000_0077, rd, rv, ms, bz);
    chk("R9 top window address", lg_addr[base+1], 32'hFF80_0004);
    chk("R9 top window be", {28'd0, lg_be[base+1]}, 32'h4);
    chk("R9 top window data", lg_wdat[base+1], 32'h0077_0000);
    base = n_log;
    host_op(1, 32'hF080_0000, 0, 2, 0, rd, rv, ms, bz);
    chk("R10 disabled neighbour miss", {31'd0, ms}, 32'd1);
    host_op(1, 32'h7000_0010, 0, 2, 0, rd, rv, ms, bz);
    chk("R10 wrong top nibble miss", {31'd0, ms}, 32'd1);
    chk("R10 no cycles on misses", n_log - base, 0);
  endtask

  task automatic t_memreg();
    logic [31:0] rd; logic rv, ms, bz; int base;
    host_op(0, 32'h060, 1, 2, 32'h0000_0000, rd, rv, ms, bz);
    host_op(0, 32'h064, 1, 2, 32'hF123_4568, rd, rv, ms, bz);
    base = n_log;
    host_op(0, 32'h070, 1, 2, 32'hDEAD_BEEF, rd, rv, ms, bz);
    chk("R11 one cycle", n_log - base, 1);
    chk("R11 kind", {30'd0, lg_kind[base]}, 32'd2);
    chk("R11 address", lg_addr[base], 32'hF123_4568);
    chk("R11 data", lg_wdat[base], 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_cfg_read();
    t_cfg_write();
    t_io();
    t_abort();
    t_window();
    t_memreg();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule